// File: doc/BRIEF.md
# Carry-save sequential multiplier

This block multiplies two unsigned WIDTH-bit operands by working through one multiplier bit per clock. The running high half of the product is kept as two separate words, a sum word and a carry word. Each step adds either the multiplicand or zero into this pair using one row of independent full adders. No carry moves from one bit position to the next during a step, so the per-step logic depth is one full adder no matter how wide the operands are. On every step the lowest sum bit retires into the top of the multiplier register, while that register shifts right. After the last step, one carry-propagate addition joins the two words into the final high word of the product.

A request is made by raising `start` for one cycle while the block is idle. The operands are captured in that cycle, and the input pins may change freely afterwards. `busy` stays high while the work is in progress. `done` pulses for one cycle when `product` becomes valid. The product then holds until the next accepted request. The interface is plain control and status: there is no back-pressure. A request that arrives while busy is dropped, and the caller must wait for `busy` to be low.

Top module: `cs_seq_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done` and `product` are all zero. A reset asserted in the middle of a multiplication abandons it.
- R2: When `start` is high and `busy` is low at a rising clock edge, `mcand` and `mplier` are captured at that edge and `busy` reads high after it. Later changes on `mcand` and `mplier` have no effect on the result.
- R3: When `start` is high while `busy` is high, the request is ignored. The running operation finishes at its normal time with its own product.
- R4: If a request is accepted at edge k, `done` is high for exactly one cycle, the cycle after edge k+WIDTH+1. This is WIDTH step cycles plus one merge cycle.
- R5: In the cycle `done` is high, `product` equals the unsigned 2·WIDTH-bit product of the captured operands, for example 9 × 5 = 0x002D. It holds that value until the next accepted request completes.
- R6: `busy` is high from the edge after acceptance up to the edge where `done` rises. `busy` and `done` are never high together.
- R7: A `start` given in the cycle where `done` is high is accepted. The new result follows WIDTH+1 cycles after that acceptance.
- R8: Boundary operands give the exact product. Zero times anything gives 0. All ones times all ones gives (2^WIDTH−1)^2, for example 0xFE01 at WIDTH 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; honoured only when idle |
| mcand | input | WIDTH | Multiplicand, captured on an accepted request |
| mplier | input | WIDTH | Multiplier, captured on an accepted request |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2*WIDTH | Unsigned product, held until the next result |

## Verification
Two events can land in the same cycle. One is the completion pulse of one operation, and the other is the acceptance of the next request. The bench provokes this by raising `start` in the very cycle it observes `done` high. It then checks two things: that the first product was correct in that cycle, and that the second product appears exactly WIDTH+1 cycles later. A request that collides with a running operation is also injected in mid-run. It is judged correct if the running result arrives on time and unchanged.

// File: rtl/cs_mult_pkg.sv
package cs_mult_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STEP  = 2'd1,
    PH_MERGE = 2'd2
  } mult_phase_t;

endpackage

// File: rtl/cs_mult_csa_row.sv
module cs_mult_csa_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum_in,
  input  logic [WIDTH-1:0] carry_in,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH-1:0] sum_out,
  output logic [WIDTH-1:0] carry_out
);

  // one independent full adder per bit position, no chain between them
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum_out[i]   = sum_in[i] ^ carry_in[i] ^ addend[i];
    assign carry_out[i] = (sum_in[i] & carry_in[i]) |
                          (sum_in[i] & addend[i])   |
                          (carry_in[i] & addend[i]);
  end

endmodule

// File: rtl/cs_mult_cpa.sv
module cs_mult_cpa #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] total
);

  logic [WIDTH-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign total[i] = op_x[i] ^ op_y[i] ^ cy[i];
    if (i < WIDTH - 1) begin : g_next
      assign cy[i+1] = (op_x[i] & op_y[i]) | (cy[i] & (op_x[i] ^ op_y[i]));
    end
  end

  // R5: the ripple chain agrees with a plain modular sum
  always_comb begin
    p_cpa_match_r5: assert (total == WIDTH'(op_x + op_y))
      else $error("ripple adder mismatch");
  end

endmodule

// File: rtl/cs_mult_ctrl.sv
module cs_mult_ctrl
  import cs_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic merge,
  output logic busy,
  output logic done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mult_phase_t phase_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  assign load  = (phase_q == PH_IDLE) && start;
  assign step  = (phase_q == PH_STEP);
  assign merge = (phase_q == PH_MERGE);
  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= merge;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_STEP;
            cnt_q   <= '0;
          end
        end
        PH_STEP: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_MERGE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_MERGE: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: completion is always preceded by a busy cycle
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R6: busy and done never overlap
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2: an idle request makes the block busy
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3: a request during stepping does not restart the count
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start && cnt_q != LAST) |=> (step && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cs_seq_mult.sv
module cs_seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic load, step, merge;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] lo_q;
  logic [WIDTH-1:0] sum_q;
  logic [WIDTH-1:0] carry_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] row_sum;
  logic [WIDTH-1:0] row_carry;
  logic [WIDTH-1:0] hi_word;

  cs_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .merge (merge),
    .busy  (busy),
    .done  (done)
  );

  assign addend = mcand_q & {WIDTH{lo_q[0]}};

  cs_mult_csa_row #(.WIDTH(WIDTH)) u_row (
    .sum_in    (sum_q),
    .carry_in  (carry_q),
    .addend    (addend),
    .sum_out   (row_sum),
    .carry_out (row_carry)
  );

  cs_mult_cpa #(.WIDTH(WIDTH)) u_cpa (
    .op_x  (sum_q),
    .op_y  (carry_q),
    .total (hi_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      lo_q    <= '0;
      sum_q   <= '0;
      carry_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand;
      lo_q    <= mplier;
      sum_q   <= '0;
      carry_q <= '0;
    end else if (step) begin
      // lowest sum bit retires into the low word; the rest slide down a place
      lo_q    <= {row_sum[0], lo_q[WIDTH-1:1]};
      sum_q   <= {1'b0, row_sum[WIDTH-1:1]};
      carry_q <= row_carry;
    end else if (merge) begin
      prod_q <= {hi_word, lo_q};
    end
  end

  assign product = prod_q;

  // R5: the result holds while idle with no request
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R3: captured multiplicand cannot change during an operation
  p_operand_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mcand_q));

  // R5: the product only changes in the cycle completion is flagged
  p_change_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

endmodule

// File: tb/cs_seq_mult_test.sv
`timescale 1ns/1ps
module cs_seq_mult_test;

  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int NV = 10;

  // each entry: {multiplicand, multiplier}
  localparam logic [2*W-1:0] VECS [NV] = '{
    16'h0905, 16'h0000, 16'hFFFF, 16'hFF01, 16'h01FF,
    16'h8080, 16'hAA55, 16'h7F81, 16'h00FF, 16'h1234
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cs_seq_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; request is sampled at the next rising edge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    start  = 1'b0;
    mcand  = ~a;
    mplier = b ^ 8'h5A;
    chk("R2 busy after accept", 32'(busy), 32'd1);
    chk("R6 no done while busy", 32'(done), 32'd0);
  endtask

  task automatic await_done(input logic [W-1:0] a, input logic [W-1:0] b, input int used);
    logic [PW-1:0] exp;
    exp = PW'(a) * PW'(b);
    repeat (W - used) @(negedge clk);
    chk("R4 no early done", 32'(done), 32'd0);
    @(negedge clk);
    chk("R4 done on time", 32'(done), 32'd1);
    chk("R6 idle at done", 32'(busy), 32'd0);
    chk("R5 product value", 32'(product), 32'(exp));
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    // R1: reset state
    @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 product in reset", 32'(product), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 product after reset", 32'(product), 32'd0);

    // vector table: R5, R8
    for (int i = 0; i < NV; i++) begin
      a = VECS[i][2*W-1:W];
      b = VECS[i][W-1:0];
      launch(a, b);
      await_done(a, b, 0);
      @(negedge clk);
      chk("R4 done one cycle", 32'(done), 32'd0);
      chk("R5 product held", 32'(product), 32'(PW'(a) * PW'(b)));
    end

    // R8 explicit boundaries
    launch(8'hFF, 8'hFF);
    await_done(8'hFF, 8'hFF, 0);
    chk("R8 all ones", 32'(product), 32'hFE01);
    @(negedge clk);
    launch(8'h00, 8'hC3);
    await_done(8'h00, 8'hC3, 0);
    chk("R8 zero operand", 32'(product), 32'h0);

    // R7: new request in the done cycle
    launch(8'h0B, 8'h0D);
    await_done(8'h0B, 8'h0D, 0);
    launch(8'hE7, 8'h3C);
    await_done(8'hE7, 8'h3C, 0);
    chk("R7 back-to-back result", 32'(product), 32'(16'hE7 * 16'h3C));

    // R3: request during an operation is ignored
    @(negedge clk);
    launch(8'h0C, 8'h0D);
    repeat (3) @(negedge clk);
    start = 1'b1; mcand = 8'hFF; mplier = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    chk("R3 still busy", 32'(busy), 32'd1);
    await_done(8'h0C, 8'h0D, 4);
    chk("R3 ignored request", 32'(product), 32'd156);
    @(negedge clk);
    chk("R3 no second result", 32'(busy), 32'd0);

    // R1: reset mid-operation abandons it
    launch(8'h55, 8'h77);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared", 32'(busy), 32'd0);
    chk("R1 product cleared", 32'(product), 32'd0);
    rst_n = 1'b1;
    repeat (W + 3) @(negedge clk);
    chk("R1 no stray done", 32'(done), 32'd0);
    chk("R1 product stays zero", 32'(product), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule